// File: doc/BRIEF.md
# Workload-Driven Power Mode Sequencer

This block watches a two-bit workload level and moves the system through a staged set of power states. When demand falls to the low level, it first selects the slower clock, then asks the supply regulator for the lower voltage, and only after the regulator confirms it gates a chosen group of modules. When demand returns, it undoes these steps in reverse. The voltage is raised and confirmed first, then the fast clock is restored, and then every module is enabled again. As a result, the fast clock never runs on the reduced supply.

Each voltage change is a level request that is held until the regulator pulses its ready acknowledge. A programmable cycle limit flags a regulator that never answers. The modules to gate come from a mask input. A parameter marks modules that must stay powered, and these are never gated. A two-bit state output tells the rest of the chip whether it runs at full, reduced or low power.

Top module: `pwr_mode_sequencer`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block enters full power. In that state `power_mode` = 2'b00, `clk_slow_sel` = 0, `vdd_low_req` = 0, `module_en` has all ones and `vreg_timeout` = 0.
- R2: `workload_lvl` codes are: 2'b00 low, 2'b01 medium, 2'b10 high, 2'b11 treated as high. Any code other than 2'b00 keeps the block at full power with unchanged outputs.
- R3: In full power, a low workload gives `clk_slow_sel` = 1 one edge later. At that point `vdd_low_req` is still 0 and `power_mode` = 2'b01 (reduced).
- R4: One edge after the clock step, if the workload is still low, `vdd_low_req` rises with `power_mode` = 2'b01. The request is held, with no further step, until `vreg_ack` is sampled high.
- R5: When `vreg_ack` is sampled high while waiting for the lower voltage and the workload is still low, the next edge gates the modules. `module_en` becomes `~gate_mask | ALWAYS_ON`, `power_mode` = 2'b10, and the clock and voltage stay reduced.
- R6: While the workload stays low in low power and the other inputs are held, the outputs do not change. `vreg_ack` pulses are ignored.
- R7: From low power, a non-low workload first drops `vdd_low_req` to 0, with the slow clock and gating kept and `power_mode` = 2'b01. After `vreg_ack`, the next edge restores the fast clock with the modules still gated. One edge later, all modules are enabled and `power_mode` = 2'b00. A low workload seen during this restore is ignored.
- R8: A non-low workload during the clock step returns the block straight to full power on the next edge.
- R9: A non-low workload while waiting for the lower voltage wins over a simultaneous `vreg_ack`. The next edge drops `vdd_low_req` and the block then completes the restore sequence of R7 with no modules gated.
- R10: Modules whose bit is set in the `ALWAYS_ON` parameter (default 8'h03) always have their `module_en` bit at 1, whatever `gate_mask` holds.
- R11: `vreg_timeout` sets once a voltage request has waited `ack_timeout` edges without `vreg_ack`. The timer restarts for each new request, `ack_timeout` = 0 disables it, and the flag stays set until reset.
- R12: `vdd_low_req` is 1 only while `clk_slow_sel` is 1, and the fast clock is never restored in a cycle that follows a low-voltage request. `power_mode` never shows 2'b11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| workload_lvl | input | 2 | Workload level code (00 low, 01 medium, 1x high) |
| vreg_ack | input | 1 | Regulator ready acknowledge pulse |
| ack_timeout | input | TW (8) | Acknowledge wait limit in cycles, 0 disables |
| gate_mask | input | NMOD (8) | Modules to switch off in low power |
| clk_slow_sel | output | 1 | 1 selects the reduced clock rate |
| vdd_low_req | output | 1 | 1 requests the reduced supply voltage |
| module_en | output | NMOD (8) | Module enable bits |
| power_mode | output | 2 | 00 full, 01 reduced, 10 low power |
| vreg_timeout | output | 1 | Sticky acknowledge timeout flag |

## Verification
The full down-and-up sequence runs once for every one of the 256 gate masks. This tells a correct mask and always-on merge apart from stuck or inverted enable bits, and it shows that gating is held until the fast clock returns. Every non-low workload code is held at full power, which separates the low code from its neighbours. A workload rise is injected at each down step, together with a simultaneous acknowledge, to show that the exits from the slow-clock step and from the voltage wait are distinct. Timeout runs hold the acknowledge off for one edge less than the limit and for exactly the limit, both on a first request and after a restart, and also with the limit at zero.

// File: rtl/pwr_seq_pkg.sv
// Package: shared state type and power-mode codes for the sequencer.
// Assumes: nothing; pure declarations.
package pwr_seq_pkg;

    typedef enum logic [2:0] {
        ST_FULL     = 3'd0,  // fast clock, high voltage, all enabled
        ST_CLK_DN   = 3'd1,  // slow clock selected, voltage high
        ST_VDN_WAIT = 3'd2,  // low voltage requested, awaiting ack
        ST_GATED    = 3'd3,  // low voltage, masked modules off
        ST_VUP_WAIT = 3'd4,  // high voltage requested, awaiting ack
        ST_CLK_UP   = 3'd5   // fast clock back, gating still held
    } seq_state_t;

    localparam logic [1:0] MODE_FULL    = 2'b00;
    localparam logic [1:0] MODE_REDUCED = 2'b01;
    localparam logic [1:0] MODE_LOW     = 2'b10;

    localparam logic [1:0] WL_LOW = 2'b00;

endpackage

// File: rtl/pwr_seq_fsm.sv
// Module: pwr_seq_fsm
// Steps through the staged power-down and reverse power-up sequence.
// Assumes: vreg_ack is a pulse sampled only in the two wait states;
// a workload rise aborts the down path, the up path always completes.
module pwr_seq_fsm
    import pwr_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wl_low,
    input  logic       vreg_ack,
    output logic       clk_reduced,
    output logic       vlow_req,
    output logic       gate_on,
    output logic       wait_active,
    output logic       wait_restart,
    output logic [1:0] mode
);

    seq_state_t state_q, state_d;
    logic       gated_q;

    // Next-state decision for the staged sequence.
    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_FULL:     if (wl_low) state_d = ST_CLK_DN;
            ST_CLK_DN:   state_d = wl_low ? ST_VDN_WAIT : ST_FULL;
            ST_VDN_WAIT: begin
                if (!wl_low)       state_d = ST_VUP_WAIT;
                else if (vreg_ack) state_d = ST_GATED;
            end
            ST_GATED:    if (!wl_low) state_d = ST_VUP_WAIT;
            ST_VUP_WAIT: if (vreg_ack) state_d = ST_CLK_UP;
            ST_CLK_UP:   state_d = ST_FULL;
            default:     state_d = ST_FULL;
        endcase
    end

    // State register and gating flag, held until full power is reached.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_FULL;
            gated_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_d == ST_GATED)     gated_q <= 1'b1;
            else if (state_d == ST_FULL) gated_q <= 1'b0;
        end
    end

    // Output decode from the current state.
    always_comb begin
        clk_reduced  = (state_q == ST_CLK_DN) || (state_q == ST_VDN_WAIT) ||
                       (state_q == ST_GATED)  || (state_q == ST_VUP_WAIT);
        vlow_req     = (state_q == ST_VDN_WAIT) || (state_q == ST_GATED);
        wait_active  = (state_q == ST_VDN_WAIT) || (state_q == ST_VUP_WAIT);
        wait_restart = (state_q == ST_VDN_WAIT) && !wl_low;
        gate_on      = gated_q;
        case (state_q)
            ST_FULL:  mode = MODE_FULL;
            ST_GATED: mode = MODE_LOW;
            default:  mode = MODE_REDUCED;
        endcase
    end

    // R12: voltage may only drop once the slow clock is already in effect.
    assert_vdrop_after_clk_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vlow_req) |-> $past(clk_reduced));

    // R7: fast clock returns only after the high-voltage request was acknowledged.
    assert_clk_up_after_volt_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(clk_reduced) |-> (!vlow_req && !$past(vlow_req)));

    // R5: gating starts only after the low-voltage request was in place.
    assert_gate_after_vdrop_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate_on) |-> ($past(vlow_req) && $past(clk_reduced)));

    // R7: gating is released only once the fast clock is back.
    assert_ungate_last_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(gate_on) |-> ($past(!clk_reduced) && !clk_reduced));

endmodule

// File: rtl/pwr_seq_ack_timer.sv
// Module: pwr_seq_ack_timer
// Counts cycles spent waiting for the regulator and raises a sticky flag.
// Assumes: limit of zero disables the check; restart marks a new request.
module pwr_seq_ack_timer #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wait_active,
    input  logic          restart,
    input  logic          ack,
    input  logic [TW-1:0] limit,
    output logic          timeout
);

    logic [TW-1:0] cnt_q;
    logic [TW-1:0] last_cnt;

    assign last_cnt = limit - TW'(1);

    // Wait-cycle counter and sticky timeout flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            timeout <= 1'b0;
        end else if (!wait_active || restart) begin
            cnt_q <= '0;
        end else if (!ack && (limit != '0)) begin
            if (cnt_q == last_cnt) timeout <= 1'b1;
            else                   cnt_q   <= cnt_q + TW'(1);
        end
    end

    // R11: once set, the flag holds until reset.
    assert_timeout_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $past(timeout) |-> timeout);

    // R11: the flag can only rise after an unacknowledged wait cycle.
    assert_timeout_cause_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(timeout) |-> ($past(wait_active) && !$past(ack) && ($past(limit) != '0)));

endmodule

// File: rtl/pwr_seq_gate.sv
// Module: pwr_seq_gate
// Builds the per-module enables from the gate flag, mask and always-on set.
// Assumes: ALWAYS_ON is fixed at build time.
module pwr_seq_gate #(
    parameter int              NMOD      = 8,
    parameter logic [NMOD-1:0] ALWAYS_ON = '0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            gate_on,
    input  logic [NMOD-1:0] mask,
    output logic [NMOD-1:0] en
);

    for (genvar i = 0; i < NMOD; i++) begin : g_bit
        if (ALWAYS_ON[i]) begin : g_keep
            // Always-on module: enable tied high.
            assign en[i] = 1'b1;
        end else begin : g_sw
            // Switchable module: off only when gating is active and masked.
            assign en[i] = !(gate_on && mask[i]);
        end
    end

    // R10: always-on modules never lose their enable.
    assert_always_on_kept_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ((en & ALWAYS_ON) == ALWAYS_ON));

    // R7: with gating inactive every module is enabled.
    assert_all_on_ungated_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !gate_on |-> (en == {NMOD{1'b1}}));

endmodule

// File: rtl/pwr_mode_sequencer.sv
// Module: pwr_mode_sequencer (top)
// Workload-driven staged power sequencer with regulator handshake.
// Assumes: workload_lvl is synchronous to clk; vreg_ack is a clk-domain pulse.
module pwr_mode_sequencer #(
    parameter int              NMOD      = 8,
    parameter int              TW        = 8,
    parameter logic [NMOD-1:0] ALWAYS_ON = 8'h03
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [1:0]      workload_lvl,
    input  logic            vreg_ack,
    input  logic [TW-1:0]   ack_timeout,
    input  logic [NMOD-1:0] gate_mask,
    output logic            clk_slow_sel,
    output logic            vdd_low_req,
    output logic [NMOD-1:0] module_en,
    output logic [1:0]      power_mode,
    output logic            vreg_timeout
);

    import pwr_seq_pkg::*;

    logic wl_low;
    logic gate_on;
    logic wait_active;
    logic wait_restart;

    assign wl_low = (workload_lvl == WL_LOW);

    pwr_seq_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .wl_low       (wl_low),
        .vreg_ack     (vreg_ack),
        .clk_reduced  (clk_slow_sel),
        .vlow_req     (vdd_low_req),
        .gate_on      (gate_on),
        .wait_active  (wait_active),
        .wait_restart (wait_restart),
        .mode         (power_mode)
    );

    pwr_seq_ack_timer #(.TW(TW)) u_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .wait_active (wait_active),
        .restart     (wait_restart),
        .ack         (vreg_ack),
        .limit       (ack_timeout),
        .timeout     (vreg_timeout)
    );

    pwr_seq_gate #(.NMOD(NMOD), .ALWAYS_ON(ALWAYS_ON)) u_gate (
        .clk     (clk),
        .rst_n   (rst_n),
        .gate_on (gate_on),
        .mask    (gate_mask),
        .en      (module_en)
    );

    // R12: the unused mode code never appears.
    assert_mode_legal_R12: assert property (@(posedge clk) disable iff (!rst_n)
        power_mode != 2'b11);

    // R12: low voltage request only with the slow clock selected.
    assert_vlow_needs_slow_R12: assert property (@(posedge clk) disable iff (!rst_n)
        vdd_low_req |-> clk_slow_sel);

    // R6: while low power holds under low workload, outputs stay put.
    assert_low_power_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (power_mode == 2'b10 && wl_low && $stable(gate_mask)) |=>
        (power_mode == 2'b10 && $stable(module_en) && vdd_low_req && clk_slow_sel));

endmodule

// File: tb/test_pwr_mode_sequencer.sv
// Bench for pwr_mode_sequencer: mask sweep, workload code sweep, abort and timeout cases.
module test_pwr_mode_sequencer;

    localparam int          NMOD = 8;
    localparam int          TW   = 8;
    localparam logic [7:0]  AON  = 8'h03;

    logic            clk = 1'b0;
    logic            rst_n;
    logic [1:0]      workload_lvl;
    logic            vreg_ack;
    logic [TW-1:0]   ack_timeout;
    logic [NMOD-1:0] gate_mask;
    logic            clk_slow_sel;
    logic            vdd_low_req;
    logic [NMOD-1:0] module_en;
    logic [1:0]      power_mode;
    logic            vreg_timeout;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;

    always #2 clk = ~clk;

    pwr_mode_sequencer i_pwr_mode_sequencer (
        .clk          (clk),
        .rst_n        (rst_n),
        .workload_lvl (workload_lvl),
        .vreg_ack     (vreg_ack),
        .ack_timeout  (ack_timeout),
        .gate_mask    (gate_mask),
        .clk_slow_sel (clk_slow_sel),
        .vdd_low_req  (vdd_low_req),
        .module_en    (module_en),
        .power_mode   (power_mode),
        .vreg_timeout (vreg_timeout)
    );

    task automatic chk(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, got, exp, $time);
        end
    endtask

    // Advance one edge; sample and drive 1 ns after it.
    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic outs(input string req, input logic cs, input logic vl,
                        input logic [7:0] en, input logic [1:0] md);
        chk(req, "clk_slow_sel", {31'b0, clk_slow_sel}, {31'b0, cs});
        chk(req, "vdd_low_req",  {31'b0, vdd_low_req},  {31'b0, vl});
        chk(req, "module_en",    {24'b0, module_en},    {24'b0, en});
        chk(req, "power_mode",   {30'b0, power_mode},   {30'b0, md});
    endtask

    task automatic pulse_ack();
        vreg_ack = 1'b1;
        tick();
        vreg_ack = 1'b0;
    endtask

    task automatic do_reset(input logic [7:0] lim);
        rst_n = 1'b0; workload_lvl = 2'b10; vreg_ack = 1'b0;
        ack_timeout = lim; gate_mask = 8'h00;
        tick(); tick();
        // R1: reset values
        outs("R1", 1'b0, 1'b0, 8'hFF, 2'b00);
        chk("R1", "vreg_timeout", {31'b0, vreg_timeout}, 32'd0);
        rst_n = 1'b1;
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] exp_en;
        #1;
        do_reset(8'd0);

        // R2: every non-low code keeps full power
        for (int c = 1; c < 4; c++) begin
            workload_lvl = 2'(c);
            tick(); tick(); tick();
            outs("R2", 1'b0, 1'b0, 8'hFF, 2'b00);
        end

        // Full down/up sequence over every gate mask
        for (int m = 0; m < 256; m++) begin
            gate_mask = 8'(m);
            exp_en = ~8'(m) | AON;
            workload_lvl = 2'b00;
            tick();
            outs("R3", 1'b1, 1'b0, 8'hFF, 2'b01);
            tick();
            outs("R4", 1'b1, 1'b1, 8'hFF, 2'b01);
            tick();
            outs("R4", 1'b1, 1'b1, 8'hFF, 2'b01);
            pulse_ack();
            outs("R5", 1'b1, 1'b1, exp_en, 2'b10);
            chk("R10", "always-on bits", {24'b0, module_en & AON}, {24'b0, AON});
            pulse_ack();
            tick();
            outs("R6", 1'b1, 1'b1, exp_en, 2'b10);
            workload_lvl = 2'(1 + (m % 3));
            tick();
            outs("R7", 1'b1, 1'b0, exp_en, 2'b01);
            workload_lvl = 2'b00;
            tick();
            outs("R7", 1'b1, 1'b0, exp_en, 2'b01);
            workload_lvl = 2'b10;
            pulse_ack();
            outs("R7", 1'b0, 1'b0, exp_en, 2'b01);
            tick();
            outs("R7", 1'b0, 1'b0, 8'hFF, 2'b00);
        end

        // R8: abort during the clock step
        gate_mask = 8'hFF;
        workload_lvl = 2'b00;
        tick();
        workload_lvl = 2'b01;
        tick();
        outs("R8", 1'b0, 1'b0, 8'hFF, 2'b00);

        // R9: abort during the voltage-down wait, with a simultaneous ack
        workload_lvl = 2'b00;
        tick(); tick();
        workload_lvl = 2'b10;
        pulse_ack();
        outs("R9", 1'b1, 1'b0, 8'hFF, 2'b01);
        tick();
        outs("R9", 1'b1, 1'b0, 8'hFF, 2'b01);
        pulse_ack();
        outs("R9", 1'b0, 1'b0, 8'hFF, 2'b01);
        tick();
        outs("R9", 1'b0, 1'b0, 8'hFF, 2'b00);

        // R11: first request times out at exactly the limit
        do_reset(8'd4);
        workload_lvl = 2'b00;
        tick(); tick();
        tick(); tick(); tick();
        chk("R11", "timeout before limit", {31'b0, vreg_timeout}, 32'd0);
        tick();
        chk("R11", "timeout at limit", {31'b0, vreg_timeout}, 32'd1);
        pulse_ack();
        workload_lvl = 2'b10;
        tick();
        pulse_ack();
        tick();
        outs("R11", 1'b0, 1'b0, 8'hFF, 2'b00);
        chk("R11", "timeout sticky", {31'b0, vreg_timeout}, 32'd1);

        // R11: restart on abort, counting begins again for the raise request
        do_reset(8'd4);
        workload_lvl = 2'b00;
        tick(); tick();
        tick(); tick();
        workload_lvl = 2'b01;
        tick();
        tick(); tick(); tick();
        chk("R11", "timeout after restart early", {31'b0, vreg_timeout}, 32'd0);
        tick();
        chk("R11", "timeout after restart", {31'b0, vreg_timeout}, 32'd1);
        pulse_ack();
        tick();

        // R11: limit zero disables the timer
        do_reset(8'd0);
        workload_lvl = 2'b00;
        tick(); tick();
        for (int k = 0; k < 20; k++) tick();
        chk("R11", "timeout disabled", {31'b0, vreg_timeout}, 32'd0);
        outs("R4", 1'b1, 1'b1, 8'hFF, 2'b01);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule